// File: doc/BRIEF.md
# Fractional 100 Hz Tick Generator with BCD Hundredths Counter

This block turns a 4096 Hz enable into a 100 Hz tick. Because 4096 / 100 = 40.96 is not a whole number, it alternates between two divide ratios. Inside each group of 25 output periods, the first 24 periods each take 41 input enables and the last period takes 40. The 25 periods together take 1024 enables, which is 250 ms. Over that window the tick rate is exactly 100 Hz, and the phase error returns to zero every 250 ms.

Each tick advances a two-digit BCD counter that runs from 00 to 99. When the counter wraps from 99 to 00 it raises a one-cycle carry toward a seconds stage. The oscillator-run input freezes the divider while the oscillator is stopped. A write port loads the counter and restarts the divide sequence at its first 41-enable period.

Top module: `hsec_tick_gen`

## Requirements
- R1: While `rst` is high, and after it is released, the outputs are `tick_100`=0, `hsec_bcd`=8'h00 and `sec_carry`=0. The divide sequence then starts at its first 41-enable period, so the first tick follows the 41st accepted enable.
- R2: `tick_100` is high for exactly one clock cycle. That cycle is the one after the clock edge at which the enable completing a period was sampled.
- R3: Periods 1 to 24 of each 25-period group take 41 accepted enables and period 25 takes 40. From a restart, 1024 accepted enables yield exactly 25 ticks, and the 1024th enable produces the 25th tick.
- R4: While `osc_run` is 0, `en_4k` is ignored. The enable count and the period index hold, and no new tick is produced.
- R5: `hsec_bcd` holds two BCD digits, tenths in bits 7:4 and hundredths in bits 3:0. It advances by one count in the clock cycle after each tick. Hundredths roll 9 to 0 with a tenths increment.
- R6: When a tick finds `hsec_bcd` = 8'h99, the counter becomes 8'h00. `sec_carry` is high for that single cycle, which is the same cycle in which 00 first appears.
- R7: A `wr_en` cycle loads `wr_data` into `hsec_bcd` on the next cycle. It clears the enable count and the period index, and it drops any pending tick and carry. A write wins over an enable or a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_4k | input | 1 | One-cycle 4096 Hz enable pulse |
| osc_run | input | 1 | Oscillator running; 0 freezes the divider |
| wr_en | input | 1 | Load strobe for the hundredths counter |
| wr_data | input | 8 | BCD value to load (tenths 7:4, hundredths 3:0) |
| tick_100 | output | 1 | One-cycle 100 Hz tick |
| hsec_bcd | output | 8 | BCD hundredths-of-seconds value |
| sec_carry | output | 1 | One-cycle carry on the 99 to 00 wrap |

## Verification
The symptoms of a wrong internal state differ by which register is corrupted:

- **Period index:** a corrupted index moves the short 40-enable period. It shows as a tick one enable early or late within at most 1024 enables, and the next 250 ms boundary drifts off the 1024-enable grid.
- **Enable count:** a corrupted count shifts the next tick at once. The whole tick train after it is then displaced.
- **Hundredths counter:** a digit error shows in `hsec_bcd` on the very next tick. A wrong wrap shows as a missing or misplaced `sec_carry` at most 100 ticks later.

The bench compares all three outputs against a cycle-by-cycle model on every clock, so each of these slips is reported in the cycle it becomes visible.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd2_t;

    // BCD increment of a two-digit value; wrap flag set on 99 -> 00
    function automatic bcd2_t bcd2_inc(input bcd2_t v, output logic wrap);
        bcd2_t r;
        r    = v;
        wrap = 1'b0;
        if (v.ones == 4'd9) begin
            r.ones = 4'd0;
            if (v.tens == 4'd9) begin
                r.tens = 4'd0;
                wrap   = 1'b1;
            end else begin
                r.tens = v.tens + 4'd1;
            end
        end else begin
            r.ones = v.ones + 4'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hsec_ratio_seq.sv
module hsec_ratio_seq #(
    parameter int DIV_LONG   = 41,
    parameter int DIV_SHORT  = 40,
    parameter int LONG_COUNT = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic restart,
    output logic tick
);
    localparam int PERIODS = LONG_COUNT + 1;
    localparam int PW      = $clog2(PERIODS);
    localparam int DW      = $clog2(DIV_LONG);
    localparam logic [DW-1:0] LAST_LONG  = DW'(DIV_LONG - 1);
    localparam logic [DW-1:0] LAST_SHORT = DW'(DIV_SHORT - 1);
    localparam logic [PW-1:0] SHORT_IDX  = PW'(LONG_COUNT);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [PW-1:0] per;
        logic          tick;
    } seq_t;

    seq_t st_d, st_q;
    logic [DW-1:0] last_cnt;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        last_cnt  = (st_q.per == SHORT_IDX) ? LAST_SHORT : LAST_LONG;
        if (restart) begin
            st_d.cnt = '0;
            st_d.per = '0;
        end else if (step) begin
            if (st_q.cnt == last_cnt) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
                st_d.per  = (st_q.per == SHORT_IDX) ? '0 : st_q.per + PW'(1);
            end else begin
                st_d.cnt = st_q.cnt + DW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/hsec_bcd_counter.sv
module hsec_bcd_counter
    import hsec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       inc,
    input  logic       load,
    input  logic [7:0] load_val,
    output logic [7:0] value,
    output logic       carry
);
    typedef struct packed {
        bcd2_t val;
        logic  carry;
    } cnt_t;

    cnt_t  st_d, st_q;
    bcd2_t inc_val;
    logic  inc_wrap;

    always_comb begin
        inc_val    = bcd2_inc(st_q.val, inc_wrap);
        st_d       = st_q;
        st_d.carry = 1'b0;
        if (load) begin
            st_d.val = bcd2_t'(load_val);
        end else if (inc) begin
            st_d.val   = inc_val;
            st_d.carry = inc_wrap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign value = st_q.val;
    assign carry = st_q.carry;

endmodule

// File: rtl/hsec_tick_gen.sv
module hsec_tick_gen #(
    parameter int DIV_LONG   = 41,
    parameter int DIV_SHORT  = 40,
    parameter int LONG_COUNT = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_4k,
    input  logic       osc_run,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       tick_100,
    output logic [7:0] hsec_bcd,
    output logic       sec_carry
);
    logic step;

    assign step = en_4k & osc_run;

    hsec_ratio_seq #(
        .DIV_LONG  (DIV_LONG),
        .DIV_SHORT (DIV_SHORT),
        .LONG_COUNT(LONG_COUNT)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .restart(wr_en),
        .tick   (tick_100)
    );

    hsec_bcd_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (tick_100),
        .load    (wr_en),
        .load_val(wr_data),
        .value   (hsec_bcd),
        .carry   (sec_carry)
    );

endmodule

// File: rtl/hsec_tick_gen_chk.sv
module hsec_tick_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       osc_run,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       tick_100,
    input logic [7:0] hsec_bcd,
    input logic       sec_carry
);
    logic seen_clk;

    always_ff @(posedge clk) seen_clk <= 1'b1;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        seen_clk && $past(rst) |-> (hsec_bcd == 8'h00) && !tick_100 && !sec_carry);

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        seen_clk && !$past(rst) && $past(tick_100) |-> !tick_100);

    // R4
    osc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        seen_clk && !$past(rst) && !$past(osc_run) |-> !tick_100);

    // R5
    count_moves_chk: assert property (@(posedge clk) disable iff (rst)
        seen_clk && !$past(rst) && $past(tick_100) && !$past(wr_en) |-> hsec_bcd != $past(hsec_bcd));

    // R6
    carry_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sec_carry |-> hsec_bcd == 8'h00);

    // R7
    write_load_chk: assert property (@(posedge clk) disable iff (rst)
        seen_clk && !$past(rst) && $past(wr_en) |-> (hsec_bcd == $past(wr_data)) && !tick_100 && !sec_carry);

endmodule

bind hsec_tick_gen hsec_tick_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .osc_run  (osc_run),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .tick_100 (tick_100),
    .hsec_bcd (hsec_bcd),
    .sec_carry(sec_carry)
);

// File: tb/sim_hsec_tick_gen.sv
module sim_hsec_tick_gen;
    logic       clk = 1'b0;
    logic       rst, en_4k, osc_run, wr_en;
    logic [7:0] wr_data;
    logic       tick_100, sec_carry;
    logic [7:0] hsec_bcd;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    int  m_cnt, m_per, m_hsec;
    bit  m_tick, m_carry;

    always #4 clk = ~clk;

    hsec_tick_gen u0 (
        .clk(clk), .rst(rst), .en_4k(en_4k), .osc_run(osc_run),
        .wr_en(wr_en), .wr_data(wr_data),
        .tick_100(tick_100), .hsec_bcd(hsec_bcd), .sec_carry(sec_carry)
    );

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int from_bcd(input int b);
        return ((b >> 4) & 15) * 10 + (b & 15);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_update();
        bit old_tick;
        int lim;
        old_tick = m_tick;
        if (rst) begin
            m_cnt = 0; m_per = 0; m_tick = 0; m_hsec = 0; m_carry = 0;
        end else if (wr_en) begin
            m_cnt = 0; m_per = 0; m_tick = 0; m_carry = 0;
            m_hsec = from_bcd(wr_data);
        end else begin
            m_carry = 0;
            m_tick  = 0;
            if (old_tick) begin
                m_carry = (m_hsec == 99);
                m_hsec  = (m_hsec + 1) % 100;
            end
            if (en_4k && osc_run) begin
                lim = (m_per == 24) ? 40 : 41;
                if (m_cnt == lim - 1) begin
                    m_cnt = 0; m_tick = 1;
                    m_per = (m_per == 24) ? 0 : m_per + 1;
                end else begin
                    m_cnt++;
                end
            end
        end
    endtask

    // one clock: apply inputs at negedge, model at posedge, compare at next negedge
    task automatic step(input bit r, input bit en, input bit osc, input bit we, input int d);
        rst = r; en_4k = en; osc_run = osc; wr_en = we; wr_data = 8'(d);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check("R2 tick", int'(tick_100), int'(m_tick));
        check("R5 hsec", int'(hsec_bcd), to_bcd(m_hsec));
        check("R6 carry", int'(sec_carry), int'(m_carry));
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ticks;
        int seed;
        int hold_val;
        seed = 1234;
        void'($urandom(seed));
        rst = 1; en_4k = 0; osc_run = 0; wr_en = 0; wr_data = 0;
        m_cnt = 0; m_per = 0; m_tick = 0; m_hsec = 0; m_carry = 0;
        @(negedge clk);
        step(1, 0, 1, 0, 0);
        step(1, 1, 1, 0, 0);
        // R1 reset state
        check("R1 hsec", int'(hsec_bcd), 0);
        check("R1 tick", int'(tick_100), 0);
        check("R1 carry", int'(sec_carry), 0);

        // R3: 1024 continuous enables give 25 ticks, the last on enable 1024
        ticks = 0;
        for (int k = 1; k <= 1024; k++) begin
            step(0, 1, 1, 0, 0);
            if (tick_100) ticks++;
            if (k == 40) check("R1 no tick at 40", int'(tick_100), 0);
            if (k == 41) check("R1 first tick at 41", int'(tick_100), 1);
            if (k == 1023) check("R3 short period not early", int'(tick_100), 0);
        end
        check("R3 tick count", ticks, 25);
        check("R3 last enable ticks", int'(tick_100), 1);
        step(0, 0, 1, 0, 0);
        check("R5 value after 25 ticks", int'(hsec_bcd), 8'h25);

        // R4: oscillator stopped, enables ignored
        for (int k = 0; k < 20; k++) step(0, 1, 1, 0, 0);
        hold_val = int'(hsec_bcd);
        ticks = 0;
        for (int k = 0; k < 200; k++) begin
            step(0, 1, 0, 0, 0);
            if (tick_100) ticks++;
        end
        check("R4 no ticks while stopped", ticks, 0);
        check("R4 value held", int'(hsec_bcd), hold_val);

        // R7: write mid-period restarts sequence
        step(0, 1, 1, 1, 8'h42);
        check("R7 loaded", int'(hsec_bcd), 8'h42);
        for (int k = 1; k <= 41; k++) begin
            step(0, 1, 1, 0, 0);
            if (k == 40) check("R7 no tick at 40", int'(tick_100), 0);
            if (k == 41) check("R7 tick at 41", int'(tick_100), 1);
        end
        // R7: write collides with pending tick
        for (int k = 1; k <= 40; k++) step(0, 1, 1, 0, 0);
        step(0, 1, 1, 1, 8'h17);
        step(0, 0, 1, 0, 0);
        check("R7 write beats tick", int'(hsec_bcd), 8'h17);

        // R6: wrap from 99
        step(0, 0, 1, 1, 8'h99);
        for (int k = 1; k <= 41; k++) step(0, 1, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        check("R6 carry on wrap", int'(sec_carry), 1);
        check("R6 zero on wrap", int'(hsec_bcd), 0);
        step(0, 0, 1, 0, 0);
        check("R6 carry one cycle", int'(sec_carry), 0);

        // random mix
        for (int k = 0; k < 60000; k++) begin
            bit en, osc, we;
            en  = ($urandom % 3) != 0;
            osc = ($urandom % 50) != 0;
            we  = ($urandom % 2000) == 0;
            step(($urandom % 20000) == 0, en, osc, we,
                 to_bcd(($urandom % 4 == 0) ? 99 : int'($urandom % 100)));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule